// File: doc/BRIEF.md
# Video Line and Frame Timing Generator

This block turns the system clock into the line and frame cadence of a television raster. A programmable line-period divider produces one single-clock hsync pulse per scan line. A line counter driven by that pulse raises a vblank level once the visible lines have been scanned. At the end of every frame it wraps, drops vblank and emits a one-clock vsync interrupt. A separate line counter issues a periodic audio-update strobe.

Two standards are supported, 60 Hz NTSC and 50 Hz PAL, selected by an input that is sampled only while reset is held. The integrator supplies the line period in clocks. It is computed as system clock / (frame rate x total lines), with 60 or 50 frames per second and 262 or 312 lines per frame. The hsync pulse is one clock wide and can serve directly as a count enable for a neighbouring timer channel.

Top module: `vid_timing_gen`

## Requirements
- R1: `hsync_pulse` is high for exactly one clock once every `line_clocks` clocks. The first pulse appears `line_clocks` clock edges after reset is released.
- R2: A `line_clocks` value of 0 or 1 makes `hsync_pulse` high on every clock.
- R3: `vblank` rises in the same cycle as the hsync pulse that brings the frame's line count to 240 in NTSC or 256 in PAL. Lines are counted from 1 after reset or after the previous frame wrap.
- R4: `vsync_irq` is a one-clock pulse in the same cycle as the hsync pulse that brings the line count to the frame total (262 NTSC, 312 PAL). The line count then restarts at zero.
- R5: `vblank` falls in the cycle `vsync_irq` fires. It changes only in cycles where `hsync_pulse` is high.
- R6: `audio_strobe` is a one-clock pulse on every 23rd (NTSC) or 22nd (PAL) hsync pulse. Its own counter runs continuously across frame wraps.
- R7: `pal_sel` is sampled only while `rst_n` is low (1 = PAL, 0 = NTSC). A change after reset release has no effect on any output.
- R8: While `rst_n` is low, all outputs are low and all counters are cleared.
- R9: When the audio count and the frame wrap land on the same line, `audio_strobe` and `vsync_irq` are both high in that cycle. In NTSC this first happens on hsync pulse 6026.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_sel | input | 1 | Standard select, sampled during reset: 1 = PAL, 0 = NTSC |
| line_clocks | input | CPL_W | Line period in system clocks |
| hsync_pulse | output | 1 | One-clock pulse per line |
| vblank | output | 1 | High from the vblank start line until the frame wrap |
| vsync_irq | output | 1 | One-clock pulse at the frame wrap |
| audio_strobe | output | 1 | One-clock pulse every audio interval of lines |

## Verification
The frame wrap and the audio strobe come from independent counters. They fall on the same hsync pulse only at common multiples of the two line counts: 6026 lines in NTSC and 3432 in PAL. With a short line period, the bench runs past that point in each standard from a fresh reset. On the shared pulse it expects `vsync_irq`, `audio_strobe` and `hsync_pulse` high together and `vblank` low. A design that lets one event suppress, delay or clear the other is caught there.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic {
        STD_NTSC = 1'b0,
        STD_PAL  = 1'b1
    } vid_std_e;

endpackage

// File: rtl/vt_line_div.sv
module vt_line_div #(
    parameter int CPL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CPL_W-1:0] line_clocks,
    output logic             wrap_o,
    output logic             tick_o
);
    typedef struct packed {
        logic [CPL_W-1:0] cnt;
        logic             tick;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CPL_W-1:0] last_c;
    logic             wrap_c;

    always_comb begin
        last_c = (line_clocks <= CPL_W'(1)) ? '0 : line_clocks - CPL_W'(1);
        wrap_c = (st_q.cnt >= last_c);
        st_d      = st_q;
        st_d.tick = wrap_c;
        st_d.cnt  = wrap_c ? '0 : st_q.cnt + CPL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wrap_o = wrap_c;
    assign tick_o = st_q.tick;
endmodule

// File: rtl/vt_frame_seq.sv
module vt_frame_seq
    import vt_pkg::*;
#(
    parameter int LN_W       = 9,
    parameter int NTSC_LINES = 262,
    parameter int PAL_LINES  = 312,
    parameter int NTSC_VBL   = 240,
    parameter int PAL_VBL    = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  vid_std_e std_i,
    input  logic     line_adv,
    output logic     vblank_o,
    output logic     frame_irq_o
);
    typedef struct packed {
        logic [LN_W-1:0] line;
        logic            vblank;
        logic            irq;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic [LN_W-1:0] total_c, vbl_c, nxt_c;

    always_comb begin
        total_c = (std_i == STD_PAL) ? LN_W'(PAL_LINES) : LN_W'(NTSC_LINES);
        vbl_c   = (std_i == STD_PAL) ? LN_W'(PAL_VBL)   : LN_W'(NTSC_VBL);
        nxt_c   = st_q.line + LN_W'(1);
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (line_adv) begin
            if (nxt_c >= total_c) begin
                st_d.line   = '0;
                st_d.vblank = 1'b0;
                st_d.irq    = 1'b1;
            end else begin
                st_d.line = nxt_c;
                if (nxt_c == vbl_c) st_d.vblank = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vblank_o    = st_q.vblank;
    assign frame_irq_o = st_q.irq;
endmodule

// File: rtl/vt_audio_tick.sv
module vt_audio_tick
    import vt_pkg::*;
#(
    parameter int AU_W     = 5,
    parameter int NTSC_AUD = 23,
    parameter int PAL_AUD  = 22
) (
    input  logic     clk,
    input  logic     rst_n,
    input  vid_std_e std_i,
    input  logic     line_adv,
    output logic     strobe_o
);
    typedef struct packed {
        logic [AU_W-1:0] cnt;
        logic            strobe;
    } aud_st_t;

    aud_st_t st_d, st_q;
    logic [AU_W-1:0] intv_c, nxt_c;

    always_comb begin
        intv_c = (std_i == STD_PAL) ? AU_W'(PAL_AUD) : AU_W'(NTSC_AUD);
        nxt_c  = st_q.cnt + AU_W'(1);
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (line_adv) begin
            if (nxt_c >= intv_c) begin
                st_d.cnt    = '0;
                st_d.strobe = 1'b1;
            end else begin
                st_d.cnt = nxt_c;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = st_q.strobe;
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
    import vt_pkg::*;
#(
    parameter int CPL_W      = 16,
    parameter int NTSC_LINES = 262,
    parameter int PAL_LINES  = 312,
    parameter int NTSC_VBL   = 240,
    parameter int PAL_VBL    = 256,
    parameter int NTSC_AUD   = 23,
    parameter int PAL_AUD    = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pal_sel,
    input  logic [CPL_W-1:0] line_clocks,
    output logic             hsync_pulse,
    output logic             vblank,
    output logic             vsync_irq,
    output logic             audio_strobe
);
    localparam int MAX_LINES = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES;
    localparam int MAX_AUD   = (PAL_AUD > NTSC_AUD) ? PAL_AUD : NTSC_AUD;
    localparam int LN_W      = $clog2(MAX_LINES + 1);
    localparam int AU_W      = $clog2(MAX_AUD + 1);

    vid_std_e std_d, std_q;
    logic     line_adv;

    always_comb std_d = std_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) std_q <= pal_sel ? STD_PAL : STD_NTSC;
        else        std_q <= std_d;
    end

    vt_line_div #(.CPL_W(CPL_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_clocks (line_clocks),
        .wrap_o      (line_adv),
        .tick_o      (hsync_pulse)
    );

    vt_frame_seq #(
        .LN_W(LN_W), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
        .NTSC_VBL(NTSC_VBL), .PAL_VBL(PAL_VBL)
    ) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .std_i       (std_q),
        .line_adv    (line_adv),
        .vblank_o    (vblank),
        .frame_irq_o (vsync_irq)
    );

    vt_audio_tick #(
        .AU_W(AU_W), .NTSC_AUD(NTSC_AUD), .PAL_AUD(PAL_AUD)
    ) u_aud (
        .clk      (clk),
        .rst_n    (rst_n),
        .std_i    (std_q),
        .line_adv (line_adv),
        .strobe_o (audio_strobe)
    );
endmodule

// File: rtl/vt_timing_chk.sv
module vt_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic hsync_pulse,
    input logic vblank,
    input logic vsync_irq,
    input logic audio_strobe
);
    a_r4_vsync_with_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq |-> hsync_pulse);

    a_r6_audio_with_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        audio_strobe |-> hsync_pulse);

    a_r5_vsync_clears_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq |-> !vblank);

    a_r3_vblank_rise_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> hsync_pulse);

    a_r5_vblank_fall_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank) |-> vsync_irq);
endmodule

bind vid_timing_gen vt_timing_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsync_pulse  (hsync_pulse),
    .vblank       (vblank),
    .vsync_irq    (vsync_irq),
    .audio_strobe (audio_strobe)
);

// File: tb/vid_timing_gen_tb.sv
module vid_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_sel = 1'b0;
    logic [15:0] line_clocks = 16'd4;
    logic        hsync_pulse, vblank, vsync_irq, audio_strobe;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    vid_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .line_clocks(line_clocks),
        .hsync_pulse(hsync_pulse), .vblank(vblank), .vsync_irq(vsync_irq),
        .audio_strobe(audio_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R8: hold reset, outputs must be low; release on a falling edge
    task automatic do_reset(input bit pal);
        @(negedge clk);
        rst_n = 1'b0;
        pal_sel = pal;
        repeat (3) @(negedge clk);
        chk(hsync_pulse == 0, "R8 hsync in reset", hsync_pulse, 0);
        chk(vblank == 0, "R8 vblank in reset", vblank, 0);
        chk(vsync_irq == 0, "R8 vsync in reset", vsync_irq, 0);
        chk(audio_strobe == 0, "R8 audio in reset", audio_strobe, 0);
        rst_n = 1'b1;
    endtask

    // Runs nlines hsync pulses right after reset release, checking every cycle
    task automatic run_lines(input int per, input bit pal, input int nlines,
                             input bit flip_sel);
        int tot_l = pal ? 312 : 262;
        int vbl_l = pal ? 256 : 240;
        int aud_l = pal ? 22 : 23;
        int gap = (per <= 1) ? 1 : per;
        int n = 0;
        int cyc = 0;
        bit vb = 0;
        bit seen_both = 0;
        if (flip_sel) pal_sel = ~pal_sel;   // R7: must be ignored
        while (n < nlines) begin
            @(negedge clk);
            cyc++;
            if (hsync_pulse) begin
                n++;
                chk(cyc == gap, "R1 hsync period", cyc, gap);
                cyc = 0;
                if (n % tot_l == 0) vb = 0;
                else if (n % tot_l == vbl_l) vb = 1;
                chk(vsync_irq == (n % tot_l == 0), "R4 vsync at frame total", vsync_irq, n % tot_l == 0);
                chk(audio_strobe == (n % aud_l == 0), "R6 audio interval", audio_strobe, n % aud_l == 0);
                chk(vblank == vb, "R3 vblank level", vblank, vb);
                if (n % tot_l == 0 && n % aud_l == 0) begin
                    seen_both = 1;
                    chk(vsync_irq && audio_strobe && !vblank, "R9 coincident strobe+vsync",
                        {vsync_irq, audio_strobe, vblank}, 3'b110);
                end
            end else begin
                if (vsync_irq || audio_strobe || vblank != vb)
                    chk(0, "R5 change off hsync", {vsync_irq, audio_strobe, vblank}, {2'b00, vb});
                if (cyc > gap) begin
                    chk(0, "R1 hsync missing", cyc, gap);
                    n = nlines;
                end
            end
        end
        if (nlines >= 6026 && !pal) chk(seen_both, "R9 coincidence reached", seen_both, 1);
    endtask

    task automatic test_reset;
        line_clocks = 16'd4;
        do_reset(1'b0);
    endtask

    task automatic test_period;
        line_clocks = 16'd7;
        do_reset(1'b0);
        run_lines(7, 1'b0, 60, 1'b0);   // R1
    endtask

    task automatic test_fast;
        line_clocks = 16'd0;
        do_reset(1'b0);
        run_lines(0, 1'b0, 30, 1'b0);   // R2 with 0
        line_clocks = 16'd1;
        do_reset(1'b1);
        run_lines(1, 1'b1, 30, 1'b0);   // R2 with 1
    endtask

    task automatic test_ntsc;
        line_clocks = 16'd4;
        do_reset(1'b0);
        run_lines(4, 1'b0, 6030, 1'b0); // R3 R4 R5 R6 R9
    endtask

    task automatic test_pal;
        line_clocks = 16'd4;
        do_reset(1'b1);
        run_lines(4, 1'b1, 3440, 1'b0); // R3 R4 R6 R9 at 3432
    endtask

    task automatic test_sel_ignored;
        line_clocks = 16'd4;
        do_reset(1'b0);
        run_lines(4, 1'b0, 530, 1'b1);  // R7: NTSC timing despite pal_sel=1
        pal_sel = 1'b0;
    endtask

    initial begin
        test_reset();
        test_period();
        test_fast();
        test_ntsc();
        test_pal();
        test_sel_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule